// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the digital front end of a 1-Mbit (128-Kbyte) serial EEPROM that answers as a slave on an I2C bus. It oversamples SCL and SDA, recognises START and STOP conditions, and decodes the device-select byte. The select byte compares one external address pin, requires one bit to be zero, and carries the most significant bit of the 17-bit byte address. After a write select it takes a high and a low address byte. It then collects up to a page of data bytes in an internal page buffer. After a read select it streams bytes out of the array, starting at its current address counter.

The array itself sits outside the block, behind a simple memory port with a one-cycle registered read. A STOP that ends a write sequence starts a program cycle of a fixed number of clock cycles. During that cycle the buffered bytes are copied into the array and the device stays silent on its select byte, so that a master can poll for completion. A high write-protect input at that STOP cancels the program cycle. The block never drives SDA high. It only raises a pull-down enable.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While rst_ni is low and right after it is released, sda_pd_o is 0 and mem_we_o is 0.
- R2: A select byte (received MSB first) is acknowledged (SDA pulled low in the 9th clock) only when bits 7:4 are 1010, bit 3 is 0 and bit 2 equals a1_i. Bit 0 selects read (1) or write (0). Any other select byte gets no acknowledge, and the bus is ignored until the next START.
- R3: A write select, whose bit 1 is address bit 16, is followed by a high and a low address byte and one data byte, each acknowledged. After STOP and the program cycle, that byte is stored at {bit 1, high, low}, and exactly one array write takes place.
- R4: Successive data bytes of one write sequence advance only address bits 6:0, wrapping from 127 to 0 inside the same 128-byte page. A later byte at an offset already written replaces the earlier one. The program cycle issues one array write per distinct offset.
- R5: A STOP that closes a write sequence holding at least one data byte starts a program cycle of T_WR clock cycles. During the cycle the select byte is not acknowledged and SDA is never pulled. After the cycle the written data reads back.
- R6: If wp_i is high at that STOP, the address and data bytes are still acknowledged, but no array write and no program cycle take place, and the very next select byte is acknowledged.
- R7: A read select streams bytes MSB first from the current address. The address advances by one for each byte placed on the bus and wraps from 0x1FFFF to 0x00000. A master ACK (SDA low in the 9th clock) continues the stream. A NACK ends it with SDA released, and the counter is left one past the last byte sent.
- R8: sda_pd_o changes only while SCL is low, after a falling SCL edge.
- R9: A repeated START at any point restarts select decoding. An address phase cut short by it leaves the address counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (resolved wire) |
| a1_i | input | 1 | Address pin compared with select bit 2 |
| wp_i | input | 1 | Write protect, high blocks array programming |
| sda_pd_o | output | 1 | SDA pull-down enable |
| mem_addr_o | output | 17 | Array byte address (read or program) |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after mem_addr_o |

## Verification
Two things can meet in the same cycle: the end of the program cycle and the evaluation of a polling select byte. The bench provokes this by sending back-to-back select polls right after a write STOP. The first poll must be refused, and the first accepted poll must come no earlier than T_WR cycles after the STOP. The data read right after that first acknowledge must already hold every byte of the sequence. The page-wrap case, where the index rolls to offset 0 in the same cycle a byte lands in the buffer, is judged by reading back the whole page together with its two neighbours.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam int ADDR_W = 17;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } bus_st_e;
endpackage

// File: rtl/eeprom_i2c_cond.sv
module eeprom_i2c_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s      = scl_q[SYNC_STAGES-1];
  assign sda_s      = sda_q[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_AW = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [PAGE_AW-1:0] widx_i,
  input  logic [7:0]         wdata_i,
  input  logic [PAGE_AW-1:0] ridx_i,
  output logic [7:0]         rdata_o,
  output logic               rvalid_o
);
  localparam int PAGE = 1 << PAGE_AW;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) data_q[widx_i] <= wdata_i;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq #(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 7,
  parameter int T_WR    = 1500
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [ADDR_W-PAGE_AW-1:0] base_i,
  input  logic                      vld_i,
  output logic                      busy_o,
  output logic [PAGE_AW-1:0]        idx_o,
  output logic                      we_o,
  output logic [ADDR_W-1:0]         addr_o
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int CW   = $clog2(T_WR + 1);

  logic [CW-1:0]             cnt_q;
  logic                      busy_q;
  logic [ADDR_W-PAGE_AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(T_WR - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= base_i;
    end
  end

  // first PAGE cycles of the busy window sweep the buffer
  assign idx_o  = cnt_q[PAGE_AW-1:0];
  assign we_o   = busy_q && (cnt_q < CW'(PAGE)) && vld_i;
  assign addr_o = {base_q, idx_o};
  assign busy_o = busy_q;

  assert_idle_go_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int PAGE_AW     = 7,
  parameter int T_WR        = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              a1_i,
  input  logic              wp_i,
  output logic              sda_pd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int BASE_W = ADDR_W - PAGE_AW;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  bus_st_e           st_q;
  logic [3:0]        bit_q;
  logic [7:0]        sh_q;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic ack_q, own_q, mack_q, sda_pd_q, a16_q, have_q;

  logic                busy, prog_we, buf_vld;
  logic [PAGE_AW-1:0]  prog_idx;
  logic [ADDR_W-1:0]   prog_addr;
  logic [7:0]          buf_rdata;
  logic rx_st, byte_done, sel_ok, buf_wr, buf_clr, prog_go;

  eeprom_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign rx_st     = st_q inside {ST_DEV, ST_AHI, ST_ALO, ST_WR};
  assign byte_done = rx_st && scl_fall && !ack_q && (bit_q == 4'd8);
  assign sel_ok    = (sh_q[7:4] == DEV_TYPE) && !sh_q[3] && (sh_q[2] == a1_i) && !busy;
  assign buf_clr   = byte_done && (st_q == ST_DEV) && sel_ok && !sh_q[0];
  assign buf_wr    = byte_done && (st_q == ST_WR);
  assign prog_go   = stop_det && (st_q == ST_WR) && have_q && !wp_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      hi_q     <= '0;
      addr_q   <= '0;
      ack_q    <= 1'b0;
      own_q    <= 1'b0;
      mack_q   <= 1'b0;
      sda_pd_q <= 1'b0;
      a16_q    <= 1'b0;
      have_q   <= 1'b0;
    end else if (start_det) begin
      st_q     <= ST_DEV;
      bit_q    <= '0;
      ack_q    <= 1'b0;
      own_q    <= 1'b0;
      sda_pd_q <= 1'b0;
    end else if (stop_det) begin
      st_q     <= ST_IDLE;
      ack_q    <= 1'b0;
      own_q    <= 1'b0;
      sda_pd_q <= 1'b0;
    end else if (st_q == ST_RD) begin
      if (scl_rise) begin
        if (ack_q) mack_q <= !sda_s;
        else       bit_q  <= bit_q + 1'b1;
      end
      if (scl_fall) begin
        if (ack_q) begin
          if (own_q || mack_q) begin
            // load next byte and advance the counter
            sh_q     <= mem_rdata_i;
            sda_pd_q <= !mem_rdata_i[7];
            addr_q   <= addr_q + 1'b1;
            bit_q    <= '0;
            ack_q    <= 1'b0;
            own_q    <= 1'b0;
            mack_q   <= 1'b0;
          end else begin
            st_q     <= ST_IDLE;
            sda_pd_q <= 1'b0;
            ack_q    <= 1'b0;
          end
        end else if (bit_q == 4'd8) begin
          sda_pd_q <= 1'b0;
          ack_q    <= 1'b1;
          mack_q   <= 1'b0;
        end else begin
          sda_pd_q <= !sh_q[6];
          sh_q     <= {sh_q[6:0], 1'b0};
        end
      end
    end else if (rx_st) begin
      if (scl_rise && !ack_q) begin
        sh_q  <= {sh_q[6:0], sda_s};
        bit_q <= bit_q + 1'b1;
      end
      if (scl_fall) begin
        if (ack_q) begin
          sda_pd_q <= 1'b0;
          ack_q    <= 1'b0;
          bit_q    <= '0;
        end else if (bit_q == 4'd8) begin
          sda_pd_q <= 1'b1;
          ack_q    <= 1'b1;
          unique case (st_q)
            ST_DEV: begin
              if (!sel_ok) begin
                st_q     <= ST_IDLE;
                sda_pd_q <= 1'b0;
                ack_q    <= 1'b0;
              end else if (sh_q[0]) begin
                st_q  <= ST_RD;
                own_q <= 1'b1;
              end else begin
                st_q   <= ST_AHI;
                a16_q  <= sh_q[1];
                have_q <= 1'b0;
              end
            end
            ST_AHI: begin
              hi_q <= sh_q;
              st_q <= ST_ALO;
            end
            ST_ALO: begin
              addr_q <= {a16_q, hi_q, sh_q};
              st_q   <= ST_WR;
            end
            default: begin
              addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
              have_q              <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  eeprom_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .wr_i     (buf_wr),
    .widx_i   (addr_q[PAGE_AW-1:0]),
    .wdata_i  (sh_q),
    .ridx_i   (prog_idx),
    .rdata_o  (buf_rdata),
    .rvalid_o (buf_vld)
  );

  eeprom_prog_seq #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .T_WR(T_WR)) u_prog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_go),
    .base_i  (addr_q[ADDR_W-1:PAGE_AW]),
    .vld_i   (buf_vld),
    .busy_o  (busy),
    .idx_o   (prog_idx),
    .we_o    (prog_we),
    .addr_o  (prog_addr)
  );

  assign sda_pd_o    = sda_pd_q;
  assign mem_addr_o  = busy ? prog_addr : addr_q;
  assign mem_we_o    = prog_we;
  assign mem_wdata_o = buf_rdata;

  logic [BASE_W-1:0] unused_base;
  assign unused_base = '0;

  assert_quiet_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_pd_q);
  assert_commit_at_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));
  assert_wp_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp_i));
  assert_stop_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pd_q);
  assert_sda_low_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_q) |-> $past(scl_fall || start_det || stop_det));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st_q == ST_DEV) && !sda_pd_q);
endmodule

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
  localparam int T_WR = 1500;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic a1 = 1'b0;
  logic wp = 1'b0;
  logic sda_pd, mem_we;
  logic sda_line;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rd;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int we_cnt = 0;
  int r8_viol = 0;
  logic pd_prev = 1'b0;

  logic [7:0] mem_arr [int];
  logic [7:0] exp_arr [int];
  logic [7:0] rd_buf [0:255];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pd;

  eeprom_i2c_slave #(.T_WR(T_WR)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .a1_i        (a1),
    .wp_i        (wp),
    .sda_pd_o    (sda_pd),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rd)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a ^ (a >> 8) ^ (a >> 16) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    return exp_arr.exists(a) ? exp_arr[a] : init_val(a);
  endfunction

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    return seed ^ 8'(i * 3);
  endfunction

  function automatic logic [7:0] sel(logic a16, logic rd);
    return {4'b1010, 1'b0, a1, a16, rd};
  endfunction

  // array model, registered read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      mem_arr[int'(mem_addr)] = mem_wdata;
      we_cnt <= we_cnt + 1;
    end
    mem_rd <= mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : init_val(int'(mem_addr));
  end

  // R8 monitor: pull-down may not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && scl && (sda_pd !== pd_prev)) r8_viol <= r8_viol + 1;
    pd_prev <= sda_pd;
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i];
      tick(Q); scl = 1'b1;
      tick(2 * Q); scl = 1'b0;
    end
    tick(Q); sda_m = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); ack = !sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic last);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1;
      tick(Q); scl = 1'b1;
      tick(Q); b[i] = sda_line;
      tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = last;
    tick(Q); scl = 1'b1;
    tick(2 * Q); scl = 1'b0;
  endtask

  task automatic do_write(input int addr, input int n, input logic [7:0] seed,
                          input logic upd, output logic all_ack);
    logic ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(sel(addr[16], 1'b0), ack); all_ack &= ack;
    send_byte(addr[15:8], ack);          all_ack &= ack;
    send_byte(addr[7:0], ack);           all_ack &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i), ack); all_ack &= ack;
      if (upd) exp_arr[(addr & ~127) | ((addr + i) & 127)] = pat(seed, i);
    end
    bus_stop();
  endtask

  task automatic do_read(input int addr, input int n);
    logic ack;
    bus_start();
    send_byte(sel(addr[16], 1'b0), ack);
    send_byte(addr[15:8], ack);
    send_byte(addr[7:0], ack);
    bus_start();
    send_byte(sel(1'b0, 1'b1), ack);
    for (int i = 0; i < n; i++) recv_byte(rd_buf[i], i == n - 1);
    bus_stop();
  endtask

  task automatic poll(output logic ack);
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack, all_ack;
    logic [7:0] b;
    int t_ret, el, n, base_we;

    tick(5);
    chk("R1 sda_pd in reset", int'(sda_pd), 0);
    chk("R1 mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda_pd after reset", int'(sda_pd), 0);
    chk("R1 mem_we after reset", we_cnt, 0);

    // R2: every select code with a1 low, then the matching nibble with a1 high
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sb;
      sb = 8'(s);
      bus_start();
      send_byte(sb, ack);
      chk("R2 select a1=0", int'(ack),
          int'(sb[7:4] == 4'hA && !sb[3] && !sb[2]));
      if (ack && sb[0]) recv_byte(b, 1'b1);
      bus_stop();
    end
    a1 = 1'b1;
    for (int s = 8'hA0; s < 8'hB0; s++) begin
      logic [7:0] sb;
      sb = 8'(s);
      bus_start();
      send_byte(sb, ack);
      chk("R2 select a1=1", int'(ack), int'(!sb[3] && sb[2]));
      if (ack && sb[0]) recv_byte(b, 1'b1);
      bus_stop();
    end
    a1 = 1'b0;
    chk("R2 no program from select-only traffic", we_cnt, 0);

    // R3: byte write with address bit 16 set
    do_write(32'h12345, 1, 8'h5A, 1'b1, all_ack);
    chk("R3 bytes acked", int'(all_ack), 1);
    tick(T_WR + 20);
    chk("R3 one array write", we_cnt, 1);
    do_read(32'h12345, 1);
    chk("R3 readback", int'(rd_buf[0]), int'(exp_rd(32'h12345)));
    do_read(32'h02345, 1);
    chk("R3 bit16 clear untouched", int'(rd_buf[0]), int'(init_val(32'h02345)));

    // R5: poll across the end of the program cycle
    base_we = we_cnt;
    do_write(32'h00200, 2, 8'h11, 1'b1, all_ack);
    t_ret = cyc;
    poll(ack);
    chk("R5 first poll refused", int'(ack), 0);
    n = 0;
    while (!ack && n < 40) begin
      poll(ack);
      n++;
    end
    el = cyc - t_ret;
    chk("R5 poll accepted", int'(ack), 1);
    chk("R5 not before T_WR", int'(el >= T_WR - 20), 1);
    chk("R5 soon after T_WR", int'(el <= T_WR + 500), 1);
    chk("R5 two array writes", we_cnt - base_we, 2);
    do_read(32'h00200, 2);
    chk("R5 data 0", int'(rd_buf[0]), int'(exp_rd(32'h00200)));
    chk("R5 data 1", int'(rd_buf[1]), int'(exp_rd(32'h00201)));

    // R4: 130 bytes from offset 0x7E of page 0x00F00
    base_we = we_cnt;
    do_write(32'h00F7E, 130, 8'h3C, 1'b1, all_ack);
    chk("R4 bytes acked", int'(all_ack), 1);
    tick(T_WR + 20);
    chk("R4 writes per distinct offset", we_cnt - base_we, 128);
    do_read(32'h00EFF, 130);
    for (int i = 0; i < 130; i++)
      chk("R4 page content", int'(rd_buf[i]), int'(exp_rd(32'h00EFF + i)));

    // R6: write protect at STOP
    wp = 1'b1;
    base_we = we_cnt;
    do_write(32'h00100, 4, 8'h77, 1'b0, all_ack);
    chk("R6 bytes acked", int'(all_ack), 1);
    poll(ack);
    chk("R6 no busy", int'(ack), 1);
    tick(T_WR + 20);
    chk("R6 no array write", we_cnt - base_we, 0);
    wp = 1'b0;
    do_read(32'h00100, 4);
    for (int i = 0; i < 4; i++)
      chk("R6 array unchanged", int'(rd_buf[i]), int'(exp_rd(32'h00100 + i)));

    // R7: stream across the top of the address space
    do_read(32'h1FFFE, 4);
    chk("R7 byte 1FFFE", int'(rd_buf[0]), int'(exp_rd(32'h1FFFE)));
    chk("R7 byte 1FFFF", int'(rd_buf[1]), int'(exp_rd(32'h1FFFF)));
    chk("R7 wrap 00000", int'(rd_buf[2]), int'(exp_rd(32'h00000)));
    chk("R7 byte 00001", int'(rd_buf[3]), int'(exp_rd(32'h00001)));
    chk("R7 sda released", int'(sda_pd), 0);

    // R9: repeated START after only the high address byte
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack);
    send_byte(8'h55, ack);
    bus_start();
    send_byte(sel(1'b0, 1'b1), ack);
    chk("R9 read select after restart", int'(ack), 1);
    recv_byte(b, 1'b1);
    bus_stop();
    chk("R9 counter kept", int'(b), int'(exp_rd(32'h00002)));

    chk("R8 sda change only with scl low", r8_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule